// File: doc/BRIEF.md
# Sparse Micro-Rotation Datapath with Gain Accumulation

This block is the arithmetic back end of an adaptive rotation-mode CORDIC for sine and cosine. An upstream angle selector chooses only the micro-rotations it needs and writes one record per rotation into a FIFO. Each record holds a constant index, a direction and an end-of-angle flag. The block pops these records, rotates an internal (x, y) vector by atan(2^-j) for each selected index j, and multiplies a running gain K by the matching factor cos(atan(2^-j)).

When the flagged record has been applied, one shared multiplier forms x·K and then y·K. Each product is packed into IEEE 754 single precision with round-to-nearest-even. The cosine register is loaded first and the sine register one clock later, when a one-cycle valid strobe is raised. Octant folding and the final sign fix-up belong to neighbouring blocks. The vector and the gain are held as sign-magnitude fixed-point values with 30 fractional bits.

Top module: `sparse_rot_gain`

## Requirements
- R1: While reset is held and after it is released with no records, out_valid, cos_out and sin_out are 0, and fifo_rd is never high while fifo_empty is high.
- R2: A record uses bits [3:0] for the index j, bit 4 for the direction (0 means d=+1, 1 means d=-1) and bit 5 as the end-of-angle flag. A record is popped on a clock edge where fifo_rd is high.
- R3: Each record applies x' = x - d·y·2^-j and y' = y + d·x·2^-j. The shifted operand is truncated toward zero, and records may arrive in any index order.
- R4: Each record multiplies K by cos(atan(2^-j)), so that the final outputs equal x·K and y·K of the real-valued rotation within a few units in the last place.
- R5: Each rotation takes two clocks. Records of one angle that are already waiting are popped exactly two clocks apart, and fifo_rd is never high on two consecutive clocks.
- R6: Every angle starts from x = 1, y = 0, K = 1, so its result does not depend on earlier angles.
- R7: cos_out and sin_out are IEEE 754 single-precision encodings of x·K and y·K, rounded to nearest-even.
- R8: If the end-of-angle record is popped on edge E, cos_out takes its new value on edge E+4. sin_out and out_valid follow on edge E+5. out_valid lasts one clock, and both outputs hold until the next angle.
- R9: No record is popped from the edge after the end-of-angle pop up to and including edge E+5.
- R10: An empty FIFO partway through an angle stalls the block. The outputs stay unchanged, no valid is raised, and the final result equals that of an uninterrupted run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_empty | input | 1 | Record FIFO has no entry |
| fifo_data | input | 6 | Head record: {last, dir, index[3:0]} |
| fifo_rd | output | 1 | Pop the head record on this edge |
| cos_out | output | 32 | Raw cosine x·K, single precision |
| sin_out | output | 32 | Raw sine y·K, single precision |
| out_valid | output | 1 | One-clock strobe: both results are new |

## Verification
Each of the sixteen indices is tried alone in both directions. These cases separate the direction encoding and check every gain-table entry and every shift amount. Multi-record angles cover ascending, descending and pseudo-random sparse index sets, which show whether the shift and gain follow the record rather than a step count. Angles queued back to back test the fresh start of each angle and the read blackout while the products are formed. A deliberate FIFO underflow partway through an angle tells a clean stall from one that corrupts the vector or the gain. Every result is compared with a real-valued rotation computed in the bench, and the pop-to-output delays are counted in clocks.

// File: rtl/srot_pkg.sv
`timescale 1ns/1ps
package srot_pkg;
  localparam int IDX_W   = 4;
  localparam int N_CONST = 1 << IDX_W;
  localparam int REC_W   = IDX_W + 2;
  localparam int MAG_W   = 31;
  localparam int FRAC    = 30;
  localparam int PROD_W  = 2 * MAG_W;
  localparam int PROD_FR = 2 * FRAC;
  localparam int FLT_W   = 32;
  localparam logic [MAG_W-1:0] ONE_M = MAG_W'(1) << FRAC;

  typedef struct packed {
    logic             s;
    logic [MAG_W-1:0] m;
  } sm_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ROT_A, ST_ROT_B, ST_FIN_X, ST_FIN_Y, ST_FIN_S
  } st_t;

  // cos(atan(2^-j)) in unsigned Q1.30
  function automatic logic [MAG_W-1:0] gain_k(input logic [IDX_W-1:0] j);
    case (j)
      4'd0:  gain_k = 31'd759250125;
      4'd1:  gain_k = 31'd960383884;
      4'd2:  gain_k = 31'd1041682578;
      4'd3:  gain_k = 31'd1065450257;
      4'd4:  gain_k = 31'd1071650796;
      4'd5:  gain_k = 31'd1073217920;
      4'd6:  gain_k = 31'd1073610776;
      4'd7:  gain_k = 31'd1073709058;
      4'd8:  gain_k = 31'd1073733632;
      4'd9:  gain_k = 31'd1073739776;
      4'd10: gain_k = 31'd1073741312;
      4'd11: gain_k = 31'd1073741696;
      4'd12: gain_k = 31'd1073741792;
      4'd13: gain_k = 31'd1073741816;
      4'd14: gain_k = 31'd1073741822;
      4'd15: gain_k = 31'd1073741823;
    endcase
  endfunction
endpackage

// File: rtl/srot_addsub.sv
`timescale 1ns/1ps
module srot_addsub #(
  parameter int MW = 31
) (
  input  logic          a_s,
  input  logic [MW-1:0] a_m,
  input  logic          b_s,
  input  logic [MW-1:0] b_m,
  input  logic          neg_b,
  output logic          r_s,
  output logic [MW-1:0] r_m,
  output logic          ovf
);
  logic          b_eff;
  logic [MW:0]   sum;
  logic [MW:0]   diff;

  always_comb begin
    b_eff = b_s ^ neg_b;
    sum   = {1'b0, a_m} + {1'b0, b_m};
    diff  = {1'b0, a_m} - {1'b0, b_m};
    ovf   = 1'b0;
    if (a_s == b_eff) begin
      r_m = sum[MW-1:0];
      r_s = a_s;
      ovf = sum[MW];
    end else if (diff[MW]) begin
      // negative difference: back to magnitude by two's complement
      r_m = ~diff[MW-1:0] + MW'(1);
      r_s = b_eff;
    end else begin
      r_m = diff[MW-1:0];
      r_s = (diff[MW-1:0] == '0) ? 1'b0 : a_s;
    end
  end
endmodule

// File: rtl/srot_f32pack.sv
`timescale 1ns/1ps
module srot_f32pack #(
  parameter int IN_W  = 62,
  parameter int IN_FR = 60
) (
  input  logic            sg,
  input  logic [IN_W-1:0] mag,
  output logic [31:0]     bits
);
  localparam int POS_W   = $clog2(IN_W);
  localparam int EXP_OFF = 127 - IN_FR;
  localparam int MANT_W  = 23;

  logic [POS_W-1:0]  pos;
  logic [POS_W-1:0]  sh;
  logic [IN_W-1:0]   norm;
  logic              lead;
  logic [MANT_W-1:0] mant;
  logic              guard;
  logic              sticky;
  logic [7:0]        expo;
  logic              rnd;

  always_comb begin
    pos = '0;
    for (int i = 0; i < IN_W; i++) begin
      if (mag[i]) pos = POS_W'(i);
    end
    sh     = POS_W'(IN_W - 1) - pos;
    norm   = mag << sh;
    lead   = norm[IN_W-1];
    mant   = norm[IN_W-2 -: MANT_W];
    guard  = norm[IN_W-2-MANT_W];
    sticky = |norm[IN_W-3-MANT_W:0];
    expo   = 8'(pos) + 8'(EXP_OFF);
    rnd    = guard & (sticky | mant[0]);
    // mantissa carry ripples into the exponent field
    bits   = lead ? ({sg, expo, mant} + 32'(rnd)) : 32'd0;
  end
endmodule

// File: rtl/srot_ctrl.sv
`timescale 1ns/1ps
module srot_ctrl
  import srot_pkg::*;
(
  input  logic clk,
  input  logic rst_ln,
  input  logic fifo_empty,
  input  logic rec_last,
  output logic fifo_rd,
  output st_t  state_o
);
  st_t st_q, st_d;

  always_comb begin
    fifo_rd = !fifo_empty &&
              ((st_q == ST_IDLE) || ((st_q == ST_ROT_B) && !rec_last));
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (fifo_rd) st_d = ST_ROT_A;
      ST_ROT_A: st_d = ST_ROT_B;
      ST_ROT_B: begin
        if (rec_last)     st_d = ST_FIN_X;
        else if (fifo_rd) st_d = ST_ROT_A;
        else              st_d = ST_IDLE;
      end
      ST_FIN_X: st_d = ST_FIN_Y;
      ST_FIN_Y: st_d = ST_FIN_S;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;

  a_r5_read_spacing: assert property (@(posedge clk) disable iff (!rst_ln)
    fifo_rd |=> !fifo_rd);
endmodule

// File: rtl/sparse_rot_gain.sv
`timescale 1ns/1ps
module sparse_rot_gain
  import srot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_empty,
  input  logic [REC_W-1:0] fifo_data,
  output logic             fifo_rd,
  output logic [FLT_W-1:0] cos_out,
  output logic [FLT_W-1:0] sin_out,
  output logic             out_valid
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ln;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ln = rst_sync_q[1];

  st_t              state;
  logic [REC_W-1:0] rec_q, rec_d;
  logic [IDX_W-1:0] rec_idx;
  logic             rec_dir;
  logic             rec_last;
  assign rec_idx  = rec_q[IDX_W-1:0];
  assign rec_dir  = rec_q[IDX_W];
  assign rec_last = rec_q[IDX_W+1];

  sm_t               x_q, x_d, y_q, y_d, k_q, k_d, t_q, t_d;
  logic              pr_s_q, pr_s_d;
  logic [PROD_W-1:0] pr_m_q, pr_m_d;
  logic [FLT_W-1:0]  cos_q, cos_d, sin_q, sin_d;
  logic              vld_q, vld_d;

  srot_ctrl u_ctrl (
    .clk        (clk),
    .rst_ln     (rst_ln),
    .fifo_empty (fifo_empty),
    .rec_last   (rec_last),
    .fifo_rd    (fifo_rd),
    .state_o    (state)
  );

  // shared add/sub: first clock forms x', second clock forms y'
  sm_t              as_a, as_b;
  logic             as_neg, as_rs, as_ovf;
  logic [MAG_W-1:0] as_rm;
  always_comb begin
    if (state == ST_ROT_B) begin
      as_a   = y_q;
      as_b.s = x_q.s;
      as_b.m = x_q.m >> rec_idx;
      as_neg = rec_dir;
    end else begin
      as_a   = x_q;
      as_b.s = y_q.s;
      as_b.m = y_q.m >> rec_idx;
      as_neg = ~rec_dir;
    end
  end

  srot_addsub #(.MW(MAG_W)) u_addsub (
    .a_s   (as_a.s),
    .a_m   (as_a.m),
    .b_s   (as_b.s),
    .b_m   (as_b.m),
    .neg_b (as_neg),
    .r_s   (as_rs),
    .r_m   (as_rm),
    .ovf   (as_ovf)
  );

  // one multiplier: gain step during rotation, x*K and y*K at the end
  sm_t               mul_a, mul_b;
  logic              mul_s;
  logic [PROD_W-1:0] mul_m;
  always_comb begin
    case (state)
      ST_FIN_X: begin mul_a = x_q; mul_b = k_q; end
      ST_FIN_Y: begin mul_a = y_q; mul_b = k_q; end
      default: begin
        mul_a   = k_q;
        mul_b.s = 1'b0;
        mul_b.m = gain_k(rec_idx);
      end
    endcase
    mul_s = mul_a.s ^ mul_b.s;
    mul_m = PROD_W'(mul_a.m) * PROD_W'(mul_b.m);
  end

  logic [FLT_W-1:0] flt;
  srot_f32pack #(.IN_W(PROD_W), .IN_FR(PROD_FR)) u_pack (
    .sg   (pr_s_q),
    .mag  (pr_m_q),
    .bits (flt)
  );

  // next-state logic
  always_comb begin
    rec_d  = rec_q;
    x_d    = x_q;
    y_d    = y_q;
    k_d    = k_q;
    t_d    = t_q;
    pr_s_d = pr_s_q;
    pr_m_d = pr_m_q;
    cos_d  = cos_q;
    sin_d  = sin_q;
    vld_d  = 1'b0;
    if (fifo_rd) rec_d = fifo_data;
    case (state)
      ST_ROT_A: begin
        t_d    = '{s: as_rs, m: as_rm};
        pr_s_d = mul_s;
        pr_m_d = mul_m;
      end
      ST_ROT_B: begin
        x_d = t_q;
        y_d = '{s: as_rs, m: as_rm};
        k_d = '{s: 1'b0, m: pr_m_q[FRAC +: MAG_W]};
      end
      ST_FIN_X: begin
        pr_s_d = mul_s;
        pr_m_d = mul_m;
      end
      ST_FIN_Y: begin
        pr_s_d = mul_s;
        pr_m_d = mul_m;
        cos_d  = flt;
        x_d    = '{s: 1'b0, m: ONE_M};
        y_d    = '{s: 1'b0, m: '0};
        k_d    = '{s: 1'b0, m: ONE_M};
      end
      ST_FIN_S: begin
        sin_d = flt;
        vld_d = 1'b1;
      end
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      rec_q  <= '0;
      x_q    <= '{s: 1'b0, m: ONE_M};
      y_q    <= '{s: 1'b0, m: '0};
      k_q    <= '{s: 1'b0, m: ONE_M};
      t_q    <= '0;
      pr_s_q <= 1'b0;
      pr_m_q <= '0;
      cos_q  <= '0;
      sin_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      rec_q  <= rec_d;
      x_q    <= x_d;
      y_q    <= y_d;
      k_q    <= k_d;
      t_q    <= t_d;
      pr_s_q <= pr_s_d;
      pr_m_q <= pr_m_d;
      cos_q  <= cos_d;
      sin_q  <= sin_d;
      vld_q  <= vld_d;
    end
  end

  assign cos_out   = cos_q;
  assign sin_out   = sin_q;
  assign out_valid = vld_q;

  a_r1_no_read_when_empty: assert property (@(posedge clk) disable iff (!rst_ln)
    fifo_empty |-> !fifo_rd);
  a_r3_no_mag_overflow: assert property (@(posedge clk) disable iff (!rst_ln)
    ((state == ST_ROT_A) || (state == ST_ROT_B)) |-> !as_ovf);
  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_ln)
    out_valid |=> !out_valid);
  a_r8_cos_leads_sin: assert property (@(posedge clk) disable iff (!rst_ln)
    out_valid |-> $stable(cos_out));
  a_r9_read_blackout: assert property (@(posedge clk) disable iff (!rst_ln)
    out_valid |-> ($past(!fifo_rd, 1) && $past(!fifo_rd, 2) && $past(!fifo_rd, 3)));
  a_r10_stall_holds: assert property (@(posedge clk) disable iff (!rst_ln)
    ((state == ST_IDLE) && fifo_empty) |=> ($stable(x_q) && $stable(y_q) && $stable(k_q)));
endmodule

// File: tb/sparse_rot_gain_tb_top.sv
`timescale 1ns/1ps
module sparse_rot_gain_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_empty = 1'b1;
  logic [5:0]  fifo_data = '0;
  logic        fifo_rd;
  logic [31:0] cos_out, sin_out;
  logic        out_valid;

  always #10 clk = ~clk;

  sparse_rot_gain dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_empty (fifo_empty),
    .fifo_data  (fifo_data),
    .fifo_rd    (fifo_rd),
    .cos_out    (cos_out),
    .sin_out    (sin_out),
    .out_valid  (out_valid)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic pop_seen = 1'b0;

  logic [5:0] recq[$];
  real        exp_c[$];
  real        exp_s[$];
  int         exp_span[$];
  int         sq_idx[16];
  int         sq_dir[16];

  int   firstpop = 0, lastpop = 0;
  bit   new_angle = 1, fin_win = 0, r9_bad = 0, prev_valid = 0;
  logic [31:0] prev_cos = '0;
  int unsigned seed = 32'h1234_5678;

  task automatic check_int(input string tag, input longint got, input longint want);
    checks++;
    if (got != want) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, want);
    end
  endtask

  task automatic check_real(input string tag, input real got, input real want);
    real tol, df;
    tol = 8.0 * (want < 0.0 ? -want : want) * (2.0 ** -24) + (2.0 ** -25);
    df  = got - want;
    if (df < 0.0) df = -df;
    checks++;
    if (df > tol) begin
      fails++;
      $display("FAIL %s actual=%.10f expected=%.10f", tag, got, want);
    end
  endtask

  function automatic real f2r(input logic [31:0] b);
    real m;
    int  e;
    if (b[30:0] == '0) return 0.0;
    e = int'(b[30:23]);
    m = (1.0 + real'(b[22:0]) / 8388608.0) * (2.0 ** (e - 127));
    return b[31] ? -m : m;
  endfunction

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 16;
  endfunction

  always @(posedge clk) begin
    cyc      <= cyc + 1;
    pop_seen <= fifo_rd;
    if (fin_win && fifo_rd) r9_bad = 1;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL R8 watchdog actual=%0d cycles expected=completion", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // FIFO model and output monitor, all at the falling edge
  always @(negedge clk) begin
    logic [5:0] r;
    real ec, es;
    int  sp;
    if (pop_seen && recq.size() != 0) begin
      r = recq.pop_front();
      if (new_angle) firstpop = cyc;
      new_angle = r[5];
      if (r[5]) begin
        lastpop = cyc;
        fin_win = 1;
        r9_bad  = 0;
      end
    end
    fifo_empty = (recq.size() == 0);
    fifo_data  = (recq.size() == 0) ? 6'd0 : recq[0];

    if (fin_win && (cyc == lastpop + 4) && exp_c.size() != 0)
      check_real("R8 cos_out loaded four edges after last pop", f2r(cos_out), exp_c[0]);
    if (prev_valid)
      check_int("R8 out_valid lasts one clock", out_valid, 0);
    if (out_valid) begin
      if (exp_c.size() == 0) begin
        fails++;
        $display("FAIL R8 out_valid actual=1 expected=0 (no angle pending)");
      end else begin
        ec = exp_c.pop_front();
        es = exp_s.pop_front();
        sp = exp_span.pop_front();
        check_real("R3 R4 R6 R7 cos_out", f2r(cos_out), ec);
        check_real("R3 R4 R6 R7 sin_out", f2r(sin_out), es);
        check_int("R8 valid delay from last pop", cyc - lastpop, 5);
        check_int("R8 cos_out stable in valid cycle", (cos_out == prev_cos) ? 1 : 0, 1);
        check_int("R9 no pop after last record", r9_bad, 0);
        if (sp >= 0) check_int("R5 two clocks per rotation", lastpop - firstpop, sp);
      end
      fin_win = 0;
      r9_bad  = 0;
    end
    prev_cos   = cos_out;
    prev_valid = out_valid;
  end

  task automatic push_angle(input int n, input int gap_at);
    real x, y, k, t, xn, d;
    logic [31:0] hold_c, hold_s;
    x = 1.0; y = 0.0; k = 1.0;
    for (int i = 0; i < n; i++) begin
      t  = 2.0 ** (-sq_idx[i]);
      d  = (sq_dir[i] != 0) ? -1.0 : 1.0;
      xn = x - d * y * t;
      y  = y + d * x * t;
      x  = xn;
      k  = k / $sqrt(1.0 + t * t);
    end
    exp_c.push_back(x * k);
    exp_s.push_back(y * k);
    exp_span.push_back(gap_at > 0 ? -1 : 2 * (n - 1));
    for (int i = 0; i < n; i++) begin
      if (gap_at > 0 && i == gap_at) begin
        while (recq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        hold_c = cos_out;
        hold_s = sin_out;
        for (int w = 0; w < 12; w++) begin
          @(negedge clk);
          check_int("R10 no valid during stall", out_valid, 0);
          check_int("R10 cos_out held during stall", (cos_out == hold_c) ? 1 : 0, 1);
          check_int("R10 sin_out held during stall", (sin_out == hold_s) ? 1 : 0, 1);
        end
      end
      recq.push_back({(i == n - 1) ? 1'b1 : 1'b0, sq_dir[i][0], sq_idx[i][3:0]});
    end
  endtask

  task automatic drain();
    while (exp_c.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic build_random(input bit reverse, output int n);
    int tmp_i[16];
    int tmp_d[16];
    n = 0;
    for (int j = 0; j < 16; j++) begin
      if ((rnd() % 3) == 0 && n < 8) begin
        tmp_i[n] = j;
        tmp_d[n] = int'(rnd() & 1);
        n++;
      end
    end
    if (n == 0) begin tmp_i[0] = 5; tmp_d[0] = 1; n = 1; end
    for (int i = 0; i < n; i++) begin
      sq_idx[i] = reverse ? tmp_i[n-1-i] : tmp_i[i];
      sq_dir[i] = reverse ? tmp_d[n-1-i] : tmp_d[i];
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check_int("R1 out_valid in reset", out_valid, 0);
    check_int("R1 cos_out in reset", cos_out, 0);
    check_int("R1 sin_out in reset", sin_out, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_int("R1 out_valid after reset", out_valid, 0);
    check_int("R1 cos_out after reset", cos_out, 0);
    check_int("R1 sin_out after reset", sin_out, 0);
    check_int("R1 no pop from empty FIFO", fifo_rd, 0);

    // R2 R4: every index alone, both directions
    for (int j = 0; j < 16; j++) begin
      for (int dr = 0; dr < 2; dr++) begin
        sq_idx[0] = j;
        sq_dir[0] = dr;
        push_angle(1, 0);
        drain();
      end
    end

    // R3: sparse ascending and descending orders
    sq_idx[0] = 1;  sq_dir[0] = 0;
    sq_idx[1] = 4;  sq_dir[1] = 0;
    sq_idx[2] = 9;  sq_dir[2] = 1;
    sq_idx[3] = 11; sq_dir[3] = 1;
    sq_idx[4] = 15; sq_dir[4] = 1;
    push_angle(5, 0);
    drain();
    sq_idx[0] = 15; sq_dir[0] = 1;
    sq_idx[1] = 12; sq_dir[1] = 0;
    sq_idx[2] = 7;  sq_dir[2] = 1;
    sq_idx[3] = 3;  sq_dir[3] = 0;
    sq_idx[4] = 0;  sq_dir[4] = 1;
    push_angle(5, 0);
    drain();
    for (int j = 0; j < 16; j++) begin
      sq_idx[j] = j;
      sq_dir[j] = j % 3 == 1 ? 1 : 0;
    end
    push_angle(16, 0);
    drain();

    // R6 R9: pseudo-random angles queued two at a time
    for (int p = 0; p < 8; p++) begin
      build_random(p[0], n);
      push_angle(n, 0);
      build_random(!p[0], n);
      push_angle(n, 0);
      drain();
    end

    // R10: FIFO underflow partway through an angle
    sq_idx[0] = 0; sq_dir[0] = 1;
    sq_idx[1] = 2; sq_dir[1] = 0;
    sq_idx[2] = 3; sq_dir[2] = 1;
    sq_idx[3] = 6; sq_dir[3] = 0;
    sq_idx[4] = 8; sq_dir[4] = 1;
    sq_idx[5] = 13; sq_dir[5] = 0;
    push_angle(6, 3);
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule